// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that were moved ahead of stores that might conflict with them. Each hardware thread has its own fully associative table. When a speculative load executes, it writes an entry holding its destination register number, its physical address and its access size. Every store, from any thread, is compared at once against every entry of every thread. An entry whose byte range overlaps the store's bytes is dropped.

When the loaded value is about to be consumed, a check names a thread and a register. The check reports whether a live entry for that register still exists. A pass means the speculatively loaded data can be used as is. A failure means the load has to be issued again. The result is registered, so it appears on the cycle after the check is presented.

A check can also be marked as clearing, so that a passing check releases its entry. A per-thread invalidate-all wipes one thread's table in a single cycle. The data path and the reissue machinery belong to the surrounding pipeline.

Top module: `sla_table`

## Requirements
- R1: After synchronous reset every entry of every thread is invalid, and both `chk_done` and `chk_pass` are low.
- R2: An allocation records register, address and size, where size code 0, 1, 2, 3 means 1, 2, 4, 8 bytes. A check of the same thread and register presented in cycle N gives `chk_done`=1 and `chk_pass`=1 after the clock edge that ends cycle N. Both outputs are low after a cycle with no check.
- R3: A check of a register that has no valid entry in the selected thread gives `chk_done`=1 and `chk_pass`=0.
- R4: A store invalidates, in all threads, every entry whose byte range [addr, addr+bytes) overlaps the store's byte range. An entry that only abuts the store's range is kept.
- R5: A check in the same cycle as a store that conflicts with the checked entry fails. A same-cycle store that does not overlap the entry leaves the check passing.
- R6: An allocation for a register that already holds an entry in that thread replaces the entry. Afterwards only the new address range is tracked for that register.
- R7: An allocation for a new register takes the lowest-numbered free entry. When the thread's table is full, the allocation evicts the entry at a per-thread round-robin pointer. The pointer starts at entry 0 after reset and advances by one with each eviction.
- R8: A passing check with `chk_clear`=1 invalidates its entry, so a second check of that register fails.
- R9: Invalidate-all clears every entry of the selected thread only. A check of that thread in the same cycle fails.
- R10: The threads' tables are independent. The same register may be live in both threads, and a check only consults the thread given by `chk_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Speculative load allocates an entry |
| alloc_tid | input | TID_W | Thread of the allocating load |
| alloc_reg | input | REG_W | Destination register of the load |
| alloc_addr | input | ADDR_W | Physical byte address of the load |
| alloc_size | input | 2 | Load size code (0:1B, 1:2B, 2:4B, 3:8B) |
| store_valid | input | 1 | A store snoops all entries |
| store_addr | input | ADDR_W | Physical byte address of the store |
| store_size | input | 2 | Store size code, same encoding |
| chk_valid | input | 1 | Consumption check request |
| chk_tid | input | TID_W | Thread being checked |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | A passing check also frees the entry |
| inv_all_valid | input | 1 | Invalidate a whole thread's table |
| inv_all_tid | input | TID_W | Thread to invalidate |
| chk_done | output | 1 | Registered: a check was presented last cycle |
| chk_pass | output | 1 | Registered: that check found a live entry |

## Verification
A wrong internal state shows up only through a later check. It reaches the ports one cycle after that check. A stale valid bit appears as a false pass. A lost entry, or one lost through a wrong victim choice, appears as a false fail on some register that should have survived. The overlap arithmetic is probed at the exact byte boundaries, so that off-by-one range comparisons turn into visible check outcomes. Round-robin state is exposed by filling a table, evicting twice and then checking which registers remain.

// File: rtl/sla_pkg.sv
package sla_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/sla_match.sv
module sla_match #(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0][1:0]        ent_size,
  input  logic [REG_W-1:0]               alloc_reg,
  input  logic [REG_W-1:0]               chk_reg,
  input  logic [ADDR_W-1:0]              st_addr,
  input  logic [1:0]                     st_size,
  output logic [ENTRIES-1:0]             alloc_hit,
  output logic [ENTRIES-1:0]             chk_hit,
  output logic [ENTRIES-1:0]             st_hit
);
  import sla_pkg::*;

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] st_lo, st_hi;

  assign st_lo = {1'b0, st_addr};
  assign st_hi = st_lo + {{(EXT_W-4){1'b0}}, size_bytes(st_size)};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [EXT_W-1:0] e_lo, e_hi;
    assign e_lo = {1'b0, ent_addr[i]};
    assign e_hi = e_lo + {{(EXT_W-4){1'b0}}, size_bytes(ent_size[i])};
    assign alloc_hit[i] = valid[i] && (ent_reg[i] == alloc_reg);
    assign chk_hit[i]   = valid[i] && (ent_reg[i] == chk_reg);
    assign st_hit[i]    = valid[i] && (e_lo < st_hi) && (st_lo < e_hi);
  end

endmodule

// File: rtl/sla_victim.sv
module sla_victim #(
  parameter int ENTRIES = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic [ENTRIES-1:0]     valid,
  input  logic [ENTRIES-1:0]     dup_hit,
  output logic [$clog2(ENTRIES)-1:0] idx
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic             found_dup, found_free, use_rr;

  always_comb begin
    idx        = rr_q;
    found_dup  = 1'b0;
    found_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (dup_hit[i] && !found_dup) begin
        idx       = IDX_W'(i);
        found_dup = 1'b1;
      end
    end
    if (!found_dup) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!valid[i] && !found_free) begin
          idx        = IDX_W'(i);
          found_free = 1'b1;
        end
      end
    end
    use_rr = !found_dup && !found_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && use_rr) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  p_rr_range_r7: assert property (@(posedge clk) disable iff (rst)
    rr_q <= LAST);

  p_rr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (take && |dup_hit) |=> $stable(rr_q));

endmodule

// File: rtl/sla_bank.sv
module sla_bank #(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_en,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  input  logic              inv_en,
  output logic              chk_ok
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][REG_W-1:0]  reg_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][1:0]        size_q;

  logic [ENTRIES-1:0] alloc_hit, chk_hit, st_hit;
  logic [ENTRIES-1:0] st_kill, chk_good, kill;
  logic [IDX_W-1:0]   vic_idx;

  sla_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) match_i (
    .valid     (valid_q),
    .ent_reg   (reg_q),
    .ent_addr  (addr_q),
    .ent_size  (size_q),
    .alloc_reg (alloc_reg),
    .chk_reg   (chk_reg),
    .st_addr   (st_addr),
    .st_size   (st_size),
    .alloc_hit (alloc_hit),
    .chk_hit   (chk_hit),
    .st_hit    (st_hit)
  );

  sla_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk     (clk),
    .rst     (rst),
    .take    (alloc_en),
    .valid   (valid_q),
    .dup_hit (alloc_hit),
    .idx     (vic_idx)
  );

  // A conflicting store or an invalidate-all in the same cycle wins over a check.
  assign st_kill  = st_en ? st_hit : '0;
  assign chk_good = chk_hit & ~st_kill & {ENTRIES{!inv_en}};
  assign chk_ok   = chk_en && |chk_good;
  assign kill     = st_kill
                  | ((chk_en && chk_clear) ? chk_good : '0)
                  | {ENTRIES{inv_en}};

  always_comb begin
    valid_d = valid_q & ~kill;
    if (alloc_en) valid_d[vic_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // Payload fields carry no reset: only the valid bits need a known state.
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      reg_q[vic_idx]  <= alloc_reg;
      addr_q[vic_idx] <= alloc_addr;
      size_q[vic_idx] <= alloc_size;
    end
  end

  p_unique_tag_r6: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> $onehot0(alloc_hit));

  p_alloc_live_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> valid_q[$past(vic_idx)]);

  p_store_kill_r4: assert property (@(posedge clk) disable iff (rst)
    (st_en && !alloc_en) |=> ((valid_q & $past(st_hit)) == '0));

  p_clear_kill_r8: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_clear && !alloc_en) |=> ((valid_q & $past(chk_good)) == '0));

  p_inv_all_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !alloc_en) |=> (valid_q == '0));

endmodule

// File: rtl/sla_table.sv
module sla_table #(
  parameter int THREADS = 2,
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [TID_W-1:0]  alloc_tid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [1:0]        store_size,
  input  logic              chk_valid,
  input  logic [TID_W-1:0]  chk_tid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  input  logic              inv_all_valid,
  input  logic [TID_W-1:0]  inv_all_tid,
  output logic              chk_done,
  output logic              chk_pass
);
  logic [THREADS-1:0] ok_vec;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    sla_bank #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) bank_i (
      .clk        (clk),
      .rst        (rst),
      .alloc_en   (alloc_valid && (alloc_tid == TID_W'(t))),
      .alloc_reg  (alloc_reg),
      .alloc_addr (alloc_addr),
      .alloc_size (alloc_size),
      .st_en      (store_valid),
      .st_addr    (store_addr),
      .st_size    (store_size),
      .chk_en     (chk_valid && (chk_tid == TID_W'(t))),
      .chk_reg    (chk_reg),
      .chk_clear  (chk_clear),
      .inv_en     (inv_all_valid && (inv_all_tid == TID_W'(t))),
      .chk_ok     (ok_vec[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_done <= 1'b0;
      chk_pass <= 1'b0;
    end else begin
      chk_done <= chk_valid;
      chk_pass <= |ok_vec;
    end
  end

  p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!chk_done && !chk_pass));

  p_pass_needs_done_r3: assert property (@(posedge clk) disable iff (rst)
    chk_pass |-> chk_done);

  p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ok_vec));

endmodule

// File: tb/sla_table_tb_top.sv
module sla_table_tb_top;
  import sla_pkg::*;

  localparam int THREADS = 2;
  localparam int ENTRIES = 32;
  localparam int REG_W   = 7;
  localparam int ADDR_W  = 32;
  localparam int TID_W   = 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              alloc_valid;
  logic [TID_W-1:0]  alloc_tid;
  logic [REG_W-1:0]  alloc_reg;
  logic [ADDR_W-1:0] alloc_addr;
  logic [1:0]        alloc_size;
  logic              store_valid;
  logic [ADDR_W-1:0] store_addr;
  logic [1:0]        store_size;
  logic              chk_valid;
  logic [TID_W-1:0]  chk_tid;
  logic [REG_W-1:0]  chk_reg;
  logic              chk_clear;
  logic              inv_all_valid;
  logic [TID_W-1:0]  inv_all_tid;
  logic              chk_done, chk_pass;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  sla_table #(.THREADS(THREADS), .ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_reg(alloc_reg),
    .alloc_addr(alloc_addr), .alloc_size(alloc_size),
    .store_valid(store_valid), .store_addr(store_addr), .store_size(store_size),
    .chk_valid(chk_valid), .chk_tid(chk_tid), .chk_reg(chk_reg), .chk_clear(chk_clear),
    .inv_all_valid(inv_all_valid), .inv_all_tid(inv_all_tid),
    .chk_done(chk_done), .chk_pass(chk_pass)
  );

  task automatic idle();
    alloc_valid = 0; alloc_tid = 0; alloc_reg = 0; alloc_addr = 0; alloc_size = 0;
    store_valid = 0; store_addr = 0; store_size = 0;
    chk_valid = 0; chk_tid = 0; chk_reg = 0; chk_clear = 0;
    inv_all_valid = 0; inv_all_tid = 0;
  endtask

  task automatic expect_bits(input logic d, input logic p, input logic ed, input logic ep,
                             input string tag);
    n_checks++;
    if (d !== ed || p !== ep) begin
      n_fail++;
      $display("FAIL %s: done/pass = %b/%b, expected %b/%b", tag, d, p, ed, ep);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic alloc(input int tid, input int r, input int addr, input int sz);
    @(negedge clk);
    idle();
    alloc_valid = 1; alloc_tid = TID_W'(tid); alloc_reg = REG_W'(r);
    alloc_addr = ADDR_W'(addr); alloc_size = 2'(sz);
    @(negedge clk);
    idle();
  endtask

  task automatic store(input int addr, input int sz);
    @(negedge clk);
    idle();
    store_valid = 1; store_addr = ADDR_W'(addr); store_size = 2'(sz);
    @(negedge clk);
    idle();
  endtask

  task automatic inv_all(input int tid);
    @(negedge clk);
    idle();
    inv_all_valid = 1; inv_all_tid = TID_W'(tid);
    @(negedge clk);
    idle();
  endtask

  // Check presented in one cycle; registered result sampled at the next falling edge.
  task automatic check(input int tid, input int r, input bit clr, input bit exp,
                       input string tag);
    @(negedge clk);
    idle();
    chk_valid = 1; chk_tid = TID_W'(tid); chk_reg = REG_W'(r); chk_clear = clr;
    @(negedge clk);
    idle();
    expect_bits(chk_done, chk_pass, 1'b1, exp, tag);
  endtask

  task automatic store_and_check(input int addr, input int sz, input int tid, input int r,
                                 input bit exp, input string tag);
    @(negedge clk);
    idle();
    store_valid = 1; store_addr = ADDR_W'(addr); store_size = 2'(sz);
    chk_valid = 1; chk_tid = TID_W'(tid); chk_reg = REG_W'(r);
    @(negedge clk);
    idle();
    expect_bits(chk_done, chk_pass, 1'b1, exp, tag);
  endtask

  task automatic inv_and_check(input int tid, input int r, input bit exp, input string tag);
    @(negedge clk);
    idle();
    inv_all_valid = 1; inv_all_tid = TID_W'(tid);
    chk_valid = 1; chk_tid = TID_W'(tid); chk_reg = REG_W'(r);
    @(negedge clk);
    idle();
    expect_bits(chk_done, chk_pass, 1'b1, exp, tag);
  endtask

  task automatic t_reset();
    do_reset();
    expect_bits(chk_done, chk_pass, 1'b0, 1'b0, "R1 outputs after reset");
    check(0, 3, 0, 0, "R1 empty table after reset");
    @(negedge clk);
    expect_bits(chk_done, chk_pass, 1'b0, 1'b0, "R2 outputs low with no check");
  endtask

  task automatic t_alloc_check();
    do_reset();
    alloc(0, 5, 'h100, SZ_B4);
    check(0, 5, 0, 1, "R2 check after allocation");
    check(0, 6, 0, 0, "R3 check of register with no entry");
  endtask

  task automatic t_store();
    do_reset();
    alloc(0, 7, 'h200, SZ_B8);
    store('h208, SZ_B1);
    check(0, 7, 0, 1, "R4 store abutting above");
    store('h1FC, SZ_B4);
    check(0, 7, 0, 1, "R4 store abutting below");
    store('h207, SZ_B1);
    check(0, 7, 0, 0, "R4 store on last byte");
    alloc(1, 7, 'h300, SZ_B2);
    store('h301, SZ_B1);
    check(1, 7, 0, 0, "R4 store snoops other thread");
  endtask

  task automatic t_same_cycle();
    do_reset();
    alloc(0, 9, 'h400, SZ_B4);
    store_and_check('h402, SZ_B1, 0, 9, 0, "R5 conflicting store same cycle");
    alloc(0, 10, 'h500, SZ_B4);
    store_and_check('h600, SZ_B8, 0, 10, 1, "R5 unrelated store same cycle");
  endtask

  task automatic t_replace();
    do_reset();
    alloc(0, 5, 'h100, SZ_B4);
    alloc(0, 5, 'h200, SZ_B4);
    store('h100, SZ_B4);
    check(0, 5, 0, 1, "R6 old range no longer tracked");
    store('h200, SZ_B1);
    check(0, 5, 0, 0, "R6 new range tracked");
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < ENTRIES; i++) alloc(0, i, 'h1000 + i * 16, SZ_B4);
    alloc(0, 40, 'h8000, SZ_B4);
    alloc(0, 41, 'h8010, SZ_B4);
    check(0, 0, 0, 0, "R7 first eviction hits entry 0");
    check(0, 1, 0, 0, "R7 second eviction hits entry 1");
    check(0, 31, 0, 1, "R7 last entry kept");
    check(0, 40, 0, 1, "R7 evicting allocation live");
    store('h1050, SZ_B1);
    alloc(0, 50, 'h9000, SZ_B4);
    check(0, 2, 0, 1, "R7 freed entry used before round robin");
    check(0, 50, 0, 1, "R7 allocation into freed entry");
  endtask

  task automatic t_clear();
    do_reset();
    alloc(0, 12, 'hA00, SZ_B2);
    check(0, 12, 1, 1, "R8 clearing check passes");
    check(0, 12, 0, 0, "R8 entry released by clearing check");
  endtask

  task automatic t_inv();
    do_reset();
    alloc(0, 13, 'hB00, SZ_B4);
    alloc(1, 13, 'hC00, SZ_B4);
    inv_all(0);
    check(0, 13, 0, 0, "R9 selected thread cleared");
    check(1, 13, 0, 1, "R9 other thread untouched");
    inv_and_check(1, 13, 0, "R9 invalidate-all same cycle as check");
  endtask

  task automatic t_threads();
    do_reset();
    alloc(0, 20, 'h700, SZ_B4);
    alloc(1, 20, 'h800, SZ_B4);
    store('h700, SZ_B1);
    check(0, 20, 0, 0, "R10 thread 0 copy killed");
    check(1, 20, 0, 1, "R10 thread 1 copy independent");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    t_reset();
    t_alloc_check();
    t_store();
    t_same_cycle();
    t_replace();
    t_round_robin();
    t_clear();
    t_inv();
    t_threads();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule